// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Receiver

This block receives asynchronous serial frames made of a low start bit, eight data bits sent least significant bit first, and a high stop bit. It is clocked by the system clock and advanced by a single-cycle enable, `tick16`, that pulses at sixteen times the baud rate. The incoming line first passes through a two-flop synchronizer. The block then watches for a high-to-low transition. When it finds one, it restarts its own sixteen-state bit timer so that the timer's wrap points match the sender's bit boundaries.

Within each bit time the line is sampled at timer states 7, 8 and 9. The bit is taken as the value that wins a two-out-of-three vote. A start bit that votes high is treated as noise, and the receiver goes back to waiting. Progress through the frame is tracked by a nine-bit shift register that is filled with ones at the start edge. Voted bits enter at the low end. When the start bit's zero reaches the top position, the next vote is the stop bit and completes the frame.

The frame is delivered only if the sticky done flag is clear and, when multiprocessor filtering is on, the stop bit is 1. On delivery the byte and the stop bit are latched and the done flag is set. Software clears the flag with `done_clr`. The `rx_enable` input gates the acceptance of new start edges.

Top module: `vote_uart_rx`

## Requirements
- R1: After synchronous reset `rx_done`, `rx_data` and `rx_stop` are 0 and the receiver waits for a falling edge; the line is taken through a two-flop synchronizer.
- R2: Each bit is decided by a 2-of-3 majority of the line sampled at timer states 7, 8 and 9, so a disturbance covering one 16x tick near mid-bit does not change the received value.
- R3: If the start bit votes 1, the frame is abandoned with no delivery and the receiver waits for a new falling edge.
- R4: On delivery `rx_data[i]` holds the i-th data bit received after the start bit (bit 0 first on the line), `rx_stop` holds the voted stop bit, and `rx_done` becomes 1.
- R5: `rx_done` stays 1 until a cycle with `done_clr` high; a frame that completes while `rx_done` is 1 is dropped and leaves `rx_data` and `rx_stop` unchanged.
- R6: With `mp_mode` high, a frame whose stop bit votes 0 is dropped; with `mp_mode` low, such a frame is delivered with `rx_stop` = 0.
- R7: While `rx_enable` is low, falling edges do not start a frame, so a whole frame sent then leaves all outputs unchanged.
- R8: After the stop-bit vote the receiver always returns to waiting, whether or not the frame was delivered, and accepts the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Single-cycle enable at 16x the baud rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_enable | input | 1 | Allows new start edges to begin reception |
| mp_mode | input | 1 | Multiprocessor filter: deliver only frames whose stop bit is 1 |
| done_clr | input | 1 | Clears the done flag |
| rx_data | output | 8 | Last delivered data byte |
| rx_stop | output | 1 | Stop bit of the last delivered frame |
| rx_done | output | 1 | Sticky flag set on delivery |

## Verification
A wrong fill or shift in the progress register shows up at the ports within the same frame. The byte comes out rotated or offset by one bit, or `rx_done` rises one bit time early or late. Checking every byte value therefore exposes it on the first frame whose bits are not all equal. A misplaced sample point or a broken vote only shows when the line is disturbed near mid-bit, so frames carrying single-tick glitches in every bit reveal it at once. Faults in the delivery condition show on the first frame that ends with the done flag still set or with a low stop bit in multiprocessor mode, as an update that should not have happened or a missing one.

// File: rtl/vurx_pkg.sv
package vurx_pkg;

    localparam int DATA_BITS = 8;
    localparam int OVERSAMPLE = 16;
    localparam int SHIFT_W = DATA_BITS + 1;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 stop;
    } rx_word_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/vurx_line_sync.sv
module vurx_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line_in,
    output logic line_s,
    output logic fall_evt
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_in;
            sync_q <= meta_q;
            if (tick) prev_q <= sync_q;
        end
    end

    assign line_s   = sync_q;
    assign fall_evt = tick & prev_q & ~sync_q;

endmodule

// File: rtl/vurx_bit_sampler.sv
module vurx_bit_sampler #(
    parameter int OVER = vurx_pkg::OVERSAMPLE
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line_s,
    input  logic restart,
    input  logic active,
    output logic vote_valid,
    output logic vote_bit
);
    localparam int CW  = $clog2(OVER);
    localparam int MID = OVER / 2;

    logic [CW-1:0] cnt_q;
    logic          samp_a_q;
    logic          samp_b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            samp_a_q   <= 1'b1;
            samp_b_q   <= 1'b1;
            vote_valid <= 1'b0;
            vote_bit   <= 1'b1;
        end else begin
            vote_valid <= 1'b0;
            if (restart) begin
                cnt_q <= '0;
            end else if (active && tick) begin
                if (cnt_q == CW'(OVER - 1)) cnt_q <= '0;
                else                        cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(MID - 1)) samp_a_q <= line_s;
                if (cnt_q == CW'(MID))     samp_b_q <= line_s;
                if (cnt_q == CW'(MID + 1)) begin
                    vote_valid <= 1'b1;
                    vote_bit   <= vurx_pkg::vote3(samp_a_q, samp_b_q, line_s);
                end
            end
        end
    end

    // R2: a decision is a single-cycle pulse, never two in a row
    assert_vote_single_R2: assert property (@(posedge clk) disable iff (rst)
        vote_valid |=> !vote_valid);

endmodule

// File: rtl/vurx_frame_ctrl.sv
module vurx_frame_ctrl
    import vurx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fall_evt,
    input  logic                 rx_enable,
    input  logic                 mp_mode,
    input  logic                 done_clr,
    input  logic                 vote_valid,
    input  logic                 vote_bit,
    output logic                 restart,
    output logic                 active,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_stop,
    output logic                 rx_done
);
    localparam logic [SHIFT_W-1:0] FILL = '1;

    rx_state_e            state_q;
    logic [SHIFT_W-1:0]   shreg_q;
    rx_word_t             word_q;
    logic                 done_q;
    logic [DATA_BITS-1:0] byte_lsb;
    logic                 start_bad;
    logic                 last_shift;
    logic                 accept;

    for (genvar g = 0; g < DATA_BITS; g++) begin : g_order
        assign byte_lsb[g] = shreg_q[DATA_BITS-1-g];
    end

    assign restart    = (state_q == RX_IDLE) && rx_enable && fall_evt;
    assign active     = (state_q == RX_BUSY);
    assign start_bad  = (shreg_q == FILL) && vote_bit;
    assign last_shift = !shreg_q[SHIFT_W-1];
    assign accept     = !done_q && (!mp_mode || vote_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            shreg_q <= FILL;
            word_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            if (done_clr) done_q <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if (restart) begin
                        state_q <= RX_BUSY;
                        shreg_q <= FILL;
                    end
                end
                RX_BUSY: begin
                    if (vote_valid) begin
                        if (start_bad) begin
                            state_q <= RX_IDLE;
                        end else if (last_shift) begin
                            state_q <= RX_IDLE;
                            if (accept) begin
                                word_q.data <= byte_lsb;
                                word_q.stop <= vote_bit;
                                done_q      <= 1'b1;
                            end
                        end else begin
                            shreg_q <= {shreg_q[SHIFT_W-2:0], vote_bit};
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign rx_data = word_q.data;
    assign rx_stop = word_q.stop;
    assign rx_done = done_q;

    // R5: flag holds until cleared
    assert_done_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !done_clr) |=> rx_done);

    // R5: no new frame lands while the flag is set
    assert_no_update_while_done_R5: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> ($stable(rx_data) && $stable(rx_stop)));

    // R6: multiprocessor filter only passes frames with a high stop bit
    assert_mp_filter_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_done) |-> (!$past(mp_mode) || rx_stop));

    // R2: bit decisions from the sampler arrive only inside a frame
    assert_vote_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
        vote_valid |-> (state_q == RX_BUSY));

    // R8: a completed frame always returns to waiting
    assert_return_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (active && vote_valid && last_shift) |=> (state_q == RX_IDLE));

endmodule

// File: rtl/vote_uart_rx.sv
module vote_uart_rx #(
    parameter int OVER = vurx_pkg::OVERSAMPLE
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           tick16,
    input  logic                           rx_line,
    input  logic                           rx_enable,
    input  logic                           mp_mode,
    input  logic                           done_clr,
    output logic [vurx_pkg::DATA_BITS-1:0] rx_data,
    output logic                           rx_stop,
    output logic                           rx_done
);
    logic line_s;
    logic fall_evt;
    logic restart;
    logic active;
    logic vote_valid;
    logic vote_bit;

    vurx_line_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .line_in  (rx_line),
        .line_s   (line_s),
        .fall_evt (fall_evt)
    );

    vurx_bit_sampler #(.OVER(OVER)) u_samp (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick16),
        .line_s     (line_s),
        .restart    (restart),
        .active     (active),
        .vote_valid (vote_valid),
        .vote_bit   (vote_bit)
    );

    vurx_frame_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .fall_evt   (fall_evt),
        .rx_enable  (rx_enable),
        .mp_mode    (mp_mode),
        .done_clr   (done_clr),
        .vote_valid (vote_valid),
        .vote_bit   (vote_bit),
        .restart    (restart),
        .active     (active),
        .rx_data    (rx_data),
        .rx_stop    (rx_stop),
        .rx_done    (rx_done)
    );

endmodule

// File: tb/tb_vote_uart_rx.sv
`timescale 1ns/1ps
module tb_vote_uart_rx;
    localparam int TDIV    = 2;
    localparam int BIT_CLK = TDIV * 16;
    localparam int LIMIT   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rx_line = 1'b1;
    logic       rx_enable = 1'b1;
    logic       mp_mode = 1'b0;
    logic       done_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_stop;
    logic       rx_done;

    int total = 0;
    int bad = 0;
    int div_cnt = 0;
    bit finished = 0;
    logic [7:0] exp_data;
    logic       exp_stop;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (div_cnt == TDIV - 1) begin
            div_cnt <= 0;
            tick16  <= 1'b1;
        end else begin
            div_cnt <= div_cnt + 1;
            tick16  <= 1'b0;
        end
    end

    vote_uart_rx dut (
        .clk       (clk),
        .rst       (rst),
        .tick16    (tick16),
        .rx_line   (rx_line),
        .rx_enable (rx_enable),
        .mp_mode   (mp_mode),
        .done_clr  (done_clr),
        .rx_data   (rx_data),
        .rx_stop   (rx_stop),
        .rx_done   (rx_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_done();
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic stopv, input bit glitch);
        for (int i = 0; i < 10; i++) begin
            logic v;
            v = (i == 0) ? 1'b0 : (i == 9) ? stopv : d[i-1];
            rx_line = v;
            repeat (BIT_CLK / 2) @(negedge clk);
            if (glitch) rx_line = ~v;
            repeat (TDIV) @(negedge clk);
            rx_line = v;
            repeat (BIT_CLK / 2 - TDIV) @(negedge clk);
        end
        rx_line = 1'b1;
        repeat (2 * BIT_CLK) @(negedge clk);
    endtask

    task automatic check_outputs(input string req, input logic done_exp);
        chk(rx_done === done_exp, req, rx_done, done_exp);
        chk(rx_data === exp_data, req, rx_data, exp_data);
        chk(rx_stop === exp_stop, req, rx_stop, exp_stop);
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", LIMIT, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset state
        exp_data = 8'h00;
        exp_stop = 1'b0;
        check_outputs("R1 reset", 1'b0);

        // R4 sweep of every byte; odd values carry mid-bit glitches (R2)
        for (int b = 0; b < 256; b++) begin
            clear_done();
            send_frame(8'(b), 1'b1, b[0]);
            exp_data = 8'(b);
            exp_stop = 1'b1;
            check_outputs(b[0] ? "R2 glitch vote" : "R4 delivery", 1'b1);
        end

        // R3: false start pulse, then valid frame
        clear_done();
        rx_line = 1'b0;
        repeat (3 * TDIV) @(negedge clk);
        rx_line = 1'b1;
        repeat (2 * BIT_CLK) @(negedge clk);
        check_outputs("R3 false start ignored", 1'b0);
        send_frame(8'hA5, 1'b1, 1'b0);
        exp_data = 8'hA5;
        check_outputs("R3 recovery frame", 1'b1);

        // R5: sticky flag, drop while set, clear
        clear_done();
        send_frame(8'h11, 1'b1, 1'b0);
        exp_data = 8'h11;
        check_outputs("R5 first frame", 1'b1);
        send_frame(8'h22, 1'b1, 1'b0);
        check_outputs("R5 dropped while done", 1'b1);
        clear_done();
        chk(rx_done === 1'b0, "R5 clear", rx_done, 0);
        send_frame(8'h22, 1'b1, 1'b0);
        exp_data = 8'h22;
        check_outputs("R5 after clear", 1'b1);

        // R6: multiprocessor filter
        clear_done();
        mp_mode = 1'b1;
        send_frame(8'h77, 1'b0, 1'b0);
        check_outputs("R6 mp drop", 1'b0);
        // R8: receiver back to waiting after a dropped frame
        send_frame(8'h55, 1'b1, 1'b0);
        exp_data = 8'h55;
        exp_stop = 1'b1;
        check_outputs("R8 after drop", 1'b1);
        clear_done();
        mp_mode = 1'b0;
        send_frame(8'h66, 1'b0, 1'b0);
        exp_data = 8'h66;
        exp_stop = 1'b0;
        check_outputs("R6 low stop delivered", 1'b1);

        // R7: enable gate
        clear_done();
        rx_enable = 1'b0;
        send_frame(8'h3C, 1'b1, 1'b0);
        check_outputs("R7 disabled", 1'b0);
        rx_enable = 1'b1;
        send_frame(8'hC3, 1'b1, 1'b1);
        exp_data = 8'hC3;
        exp_stop = 1'b1;
        check_outputs("R7 re-enabled", 1'b1);

        // R1: reset again clears outputs
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        exp_data = 8'h00;
        exp_stop = 1'b0;
        check_outputs("R1 second reset", 1'b0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule